// File: doc/BRIEF.md
# Masked Interrupt Register Bank

This block gathers ten hardware interrupt sources behind a 32-bit register bus and drives one level-sensitive interrupt line. Each source owns one bit in a sticky status register. A one-cycle pulse on a hardware event input sets that bit. Software clears status bits by writing ones to the status register. For test purposes, software can also force status bits high through a trigger register.

Each source also has a mask bit. The mask register can be read but cannot be written directly. Software changes it only through two companion registers. A write to the enable register clears the mask bits at the positions where the written value holds ones. A write to the disable register sets them. The interrupt line is high whenever some status bit is set while its mask bit is clear. The line follows the register contents with no extra delay.

Register offsets (byte addresses, 32-bit accesses, full address compared): status 0x00, mask 0x04, enable 0x08, disable 0x0C, trigger 0x10. Every other address is unmapped. Read data is combinational from the current address.

Top module: `irq_mask_bank`

## Requirements
- R1: After reset, status reads 0x000, mask reads 0x3FF (all ten sources masked) and the interrupt output is low.
- R2: A high level on hardware event input bit i during a clock edge sets status bit i at that edge.
- R3: A write to offset 0x00 clears each status bit whose write-data bit is 1 and leaves the bits written with 0 unchanged.
- R4: If a hardware event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: A write to the mask offset 0x04 leaves the mask unchanged.
- R6: A write to offset 0x08 clears each mask bit whose write-data bit is 1; the other mask bits are unchanged.
- R7: A write to offset 0x0C sets each mask bit whose write-data bit is 1; the other mask bits are unchanged.
- R8: A write to offset 0x10 sets each status bit whose write-data bit is 1; the other status bits are unchanged.
- R9: The interrupt output equals the OR over i of (status[i] AND NOT mask[i]). It reflects the state produced by the latest clock edge.
- R10: Reads of status and mask return the bits in [9:0] with [31:10] zero. Reads of offsets 0x08, 0x0C, 0x10 and of any unmapped address return zero.
- R11: Write-data bits [31:10] have no effect. A write to an unmapped address (for example 0x14 or the unaligned 0x01) changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_event | input | 10 | Hardware event inputs, one per source |
| bus_wr | input | 1 | Write strobe, one write per cycle in which it is high |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_out | output | 1 | Level interrupt output |

## Verification
The bench builds the block with its default values: ten sources, a 32-bit data word and an 8-bit address. This lets every source bit, the reserved upper data bits and the addresses just past the last register (0x14) and between registers (0x01) be driven directly. A behavioural model tracks status and mask and is compared on every clock against the interrupt line and the read data at the current address. The directed cases include a set and a clear landing on the same bit, writes to the read-only mask, and writes carrying only reserved bits. A long random phase then mixes events with writes to every offset.

// File: rtl/irqb_pkg.sv
package irqb_pkg;

  localparam int OFS_STATUS  = 'h00;
  localparam int OFS_MASK    = 'h04;
  localparam int OFS_ENABLE  = 'h08;
  localparam int OFS_DISABLE = 'h0C;
  localparam int OFS_TRIGGER = 'h10;

  typedef struct packed {
    logic clr;   // write-one-to-clear on status
    logic en;    // clear mask bits
    logic dis;   // set mask bits
    logic trig;  // set status bits
  } wr_strobe_t;

endpackage

// File: rtl/irqb_decode.sv
module irqb_decode #(
  parameter int ADDR_W = 8
) (
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  output irqb_pkg::wr_strobe_t strb,
  output logic                 sel_status,
  output logic                 sel_mask
);
  import irqb_pkg::*;

  logic hit_en, hit_dis, hit_trig;

  always_comb begin
    sel_status = (bus_addr == ADDR_W'(OFS_STATUS));
    sel_mask   = (bus_addr == ADDR_W'(OFS_MASK));
    hit_en     = (bus_addr == ADDR_W'(OFS_ENABLE));
    hit_dis    = (bus_addr == ADDR_W'(OFS_DISABLE));
    hit_trig   = (bus_addr == ADDR_W'(OFS_TRIGGER));
    strb.clr   = bus_wr & sel_status;
    strb.en    = bus_wr & hit_en;
    strb.dis   = bus_wr & hit_dis;
    strb.trig  = bus_wr & hit_trig;
  end

endmodule

// File: rtl/irqb_status.sv
module irqb_status #(
  parameter int NUM_SRC = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] hw_event,
  input  logic               clr_wr,
  input  logic               trig_wr,
  input  logic [NUM_SRC-1:0] wbits,
  output logic [NUM_SRC-1:0] status
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic set_i, clr_i;
    assign set_i = hw_event[i] | (trig_wr & wbits[i]);
    assign clr_i = clr_wr & wbits[i];

    // set has priority over clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      status[i] <= 1'b0;
      else if (set_i)  status[i] <= 1'b1;
      else if (clr_i)  status[i] <= 1'b0;
    end

    // R2: event input sets its bit
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      hw_event[i] |=> status[i]);

    // R4: event wins over a simultaneous clear
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && wbits[i] && hw_event[i]) |=> status[i]);

    // R3: a clear with no competing set empties the bit
    a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && wbits[i] && !hw_event[i] && !trig_wr) |=> !status[i]);

    // R8: trigger raises the bit
    a_r8_trigger_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_wr && wbits[i]) |=> status[i]);
  end

endmodule

// File: rtl/irqb_mask.sv
module irqb_mask #(
  parameter int NUM_SRC = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_wr,
  input  logic               dis_wr,
  input  logic [NUM_SRC-1:0] wbits,
  output logic [NUM_SRC-1:0] mask
);

  localparam logic [NUM_SRC-1:0] MASK_RST = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask <= MASK_RST;
    else if (en_wr)  mask <= mask & ~wbits;
    else if (dis_wr) mask <= mask | wbits;
  end

  // R6: enable clears the selected bits and keeps the rest
  a_r6_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> ((mask & $past(wbits)) == '0) &&
              ((mask | $past(wbits)) == ($past(mask) | $past(wbits))));

  // R7: disable sets the selected bits and keeps the rest
  a_r7_disable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    dis_wr |=> ((mask & $past(wbits)) == $past(wbits)) &&
               ((mask & ~$past(wbits)) == ($past(mask) & ~$past(wbits))));

  // R5: without an enable or disable strobe the mask holds
  a_r5_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_wr && !dis_wr) |=> $stable(mask));

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int NUM_SRC = 10,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] hw_event,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_out
);
  import irqb_pkg::*;

  localparam int PAD_W = DATA_W - NUM_SRC;

  wr_strobe_t         strb;
  logic               sel_status, sel_mask;
  logic [NUM_SRC-1:0] wbits, status, mask;

  assign wbits = bus_wdata[NUM_SRC-1:0];

  if (PAD_W > 0) begin : g_pad
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];
  end

  irqb_decode #(.ADDR_W(ADDR_W)) u_decode (
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .strb       (strb),
    .sel_status (sel_status),
    .sel_mask   (sel_mask)
  );

  irqb_status #(.NUM_SRC(NUM_SRC)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_event (hw_event),
    .clr_wr   (strb.clr),
    .trig_wr  (strb.trig),
    .wbits    (wbits),
    .status   (status)
  );

  irqb_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_wr  (strb.en),
    .dis_wr (strb.dis),
    .wbits  (wbits),
    .mask   (mask)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_status)    bus_rdata[NUM_SRC-1:0] = status;
    else if (sel_mask) bus_rdata[NUM_SRC-1:0] = mask;
  end

  assign irq_out = |(status & ~mask);

  // R10: reserved read bits stay zero
  a_r10_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (bus_rdata >> NUM_SRC) == '0);

  // R9: a raised line needs an unmasked pending source from the last edge
  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> (status != '0) && (mask != '1));

  // R11: a write to an unmapped address disturbs neither register
  a_r11_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !sel_status && !sel_mask && !strb.en && !strb.dis && !strb.trig &&
     hw_event == '0) |=> $stable(status) && $stable(mask));

endmodule

// File: tb/tb_irq_mask_bank.sv
module tb_irq_mask_bank;

  localparam int N = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] hw_event = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [N-1:0] m_status, m_mask;

  always #10 clk = ~clk;

  irq_mask_bank dut (
    .clk(clk), .rst_n(rst_n), .hw_event(hw_event), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00:   return {22'd0, m_status};
      8'h04:   return {22'd0, m_mask};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check_outputs(input string tag);
    logic [31:0] exp_rd;
    logic        exp_irq;
    exp_rd  = model_read(bus_addr);
    exp_irq = |(m_status & ~m_mask);
    checks++;
    if (bus_rdata !== exp_rd) begin
      fails++;
      $display("FAIL %s rdata@%h act %h exp %h", tag, bus_addr, bus_rdata, exp_rd);
    end
    checks++;
    if (irq_out !== exp_irq) begin
      fails++;
      $display("FAIL %s irq act %b exp %b", tag, irq_out, exp_irq);
    end
  endtask

  task automatic step(input logic [N-1:0] ev, input logic wr,
                      input logic [7:0] a, input logic [31:0] wd, input string tag);
    logic [N-1:0] w;
    @(negedge clk);
    hw_event = ev; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    @(posedge clk);
    w = wd[N-1:0];
    if (wr) begin
      case (a)
        8'h00: m_status = m_status & ~w;
        8'h08: m_mask   = m_mask & ~w;
        8'h0C: m_mask   = m_mask | w;
        8'h10: m_status = m_status | w;
        default: ;
      endcase
    end
    m_status = m_status | ev;
    #2;
    check_outputs(tag);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step('0, 1'b0, a, 32'hFFFF_FFFF, tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_status = '0;
    m_mask   = '1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check_outputs("R1 reset status");
    rd(8'h04, "R1 reset mask");
    rd(8'h00, "R1 reset status read");

    step(10'h008, 1'b0, 8'h00, 0, "R2 event sets bit3");
    step(10'h000, 1'b1, 8'h08, 32'h8, "R6 enable bit3 / R9 irq");
    rd(8'h04, "R6 mask read");
    step(10'h000, 1'b1, 8'h04, 32'h0, "R5 direct mask write ignored");
    rd(8'h04, "R5 mask unchanged");
    step(10'h000, 1'b1, 8'h00, 32'h0, "R3 zero write keeps status");
    step(10'h000, 1'b1, 8'h00, 32'h8, "R3 w1c bit3");
    step(10'h020, 1'b0, 8'h00, 0, "R2 event bit5");
    step(10'h020, 1'b1, 8'h00, 32'h20, "R4 set beats clear");
    step(10'h000, 1'b1, 8'h08, 32'h3FF, "R6 enable all / R9");
    step(10'h000, 1'b1, 8'h0C, 32'h3DF, "R7 disable partial");
    rd(8'h04, "R7 mask read");
    step(10'h000, 1'b1, 8'h0C, 32'h020, "R7 disable bit5 / R9 irq low");
    step(10'h000, 1'b1, 8'h10, 32'h201, "R8 trigger bits 9,0");
    rd(8'h00, "R8 status read");
    rd(8'h08, "R10 enable reads zero");
    rd(8'h0C, "R10 disable reads zero");
    rd(8'h10, "R10 trigger reads zero");
    rd(8'h14, "R10 unmapped reads zero");
    step(10'h000, 1'b1, 8'h10, 32'hFFFF_FC00, "R11 reserved bits trigger");
    rd(8'h00, "R11 status unchanged");
    step(10'h000, 1'b1, 8'h14, 32'hFFFF_FFFF, "R11 unmapped 0x14 write");
    step(10'h000, 1'b1, 8'h01, 32'hFFFF_FFFF, "R11 unaligned 0x01 write");
    rd(8'h00, "R11 status after unmapped");
    rd(8'h04, "R11 mask after unmapped");

    for (int k = 0; k < 3000; k++) begin
      logic [7:0] a;
      logic [N-1:0] ev;
      case ($urandom_range(0, 6))
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C;
        4: a = 8'h10; 5: a = 8'h14; default: a = 8'h00;
      endcase
      ev = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
      step(ev, 1'($urandom_range(0, 1)), a, $urandom, "R9 random mix");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule